// File: doc/BRIEF.md
# Oversampling UART Receiver with Fractional Bit Timing

This block receives asynchronous serial characters. The line is taken through a flop synchronizer, and each bit is then observed at sixteen sample points. A programmable divisor sets how many clock cycles one bit lasts. The divisor does not have to be a multiple of sixteen. The timing generator gives each sample interval the base length floor(div/16). It then adds one extra cycle to each of the last (div mod 16) intervals of the bit. As a result, every bit lasts exactly div cycles and sampling does not slide away from the bit centres over a long frame. This matters most when the divisor is only a little larger than sixteen, because the remainder is then a large share of the bit.

A frame begins on a falling edge of the idle-high line. The receiver votes over the three samples around the bit centre to confirm the start bit, shifts in eight data bits least significant first, and then tests the stop bit. A good stop bit delivers the byte with a one-cycle valid pulse. A low stop bit gives a one-cycle framing-error pulse instead. When the enable is low, the receiver stays idle.

Top module: `uart_os_rx`

## Requirements
- R1: The serial input passes through two synchronizing flops, both reset high, before any other logic uses it. The frame logic acts on the line value only after that two-cycle delay.
- R2: With div >= 16, base = floor(div/16) and r = div mod 16. Sample interval k (k = 0..15) lasts base cycles for k < 16-r and base+1 cycles otherwise, so every bit lasts exactly div cycles.
- R3: With div < 16, every sample interval lasts one cycle, so a bit lasts 16 cycles.
- R4: In idle, a high-to-low change of the synchronized line starts a frame. If the majority of samples 7, 8 and 9 of the start bit is high, the receiver returns to idle and produces no output.
- R5: Eight data bits follow the start bit, least significant first. Each bit value is the majority of its samples 7, 8 and 9, so one disturbed sample does not change the value.
- R6: When the stop bit (bit 9 of the frame) votes high, rx_valid is high for exactly one cycle and rx_data carries the byte. Counting posedges after the start bit reaches the pin, rx_valid is visible after posedge 3 + 9*L + S, where L is the bit length and S is the sum of the first ten interval lengths.
- R7: When the stop bit votes low, rx_ferr is high for one cycle at the same point in time, and rx_valid stays low. rx_valid and rx_ferr are never high together.
- R8: While en is low, the receiver is held idle and neither rx_valid nor rx_ferr is asserted in the following cycle.
- R9: Frames sent back to back, with the next start bit right after the stop bit, are each decoded correctly.
- R10: After reset, rx_valid and rx_ferr are low and rx_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Receiver enable; low holds it idle |
| div | input | 16 | Clock cycles per serial bit |
| rxd_raw | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle pulse when rx_data is updated |
| rx_ferr | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The bench uses the default parameters: 16 samples per bit, a 16-bit divisor and 8 data bits. This allows divisors of 5, 16, 17, 20, 23, 31, 47 and 64. The set covers the clamped case below sixteen, zero remainder, remainders small enough to stretch no centre interval, and remainders up to fifteen, where most intervals are stretched. Because the timing is exact, the bench can predict the cycle of every valid pulse from the divisor alone. So a dropped or misplaced remainder cycle changes the measured latency. With a divisor of 64, each interval is four cycles long. At that divisor, a three-cycle disturbance can be placed on a single centre sample to test the vote.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the oversampling UART receiver.
// Assumes nothing beyond a single clock domain.
package uart_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // Two-of-three vote over centre samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
// Flop synchronizer for the asynchronous serial line.
// Assumes the idle level is high, so every stage resets to one.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_tick.sv
// Sample-strobe generator. It splits each bit of div cycles into OSR
// intervals of floor(div/OSR) cycles and stretches the last (div mod OSR)
// intervals by one cycle each. It clamps to one cycle per interval when
// div < OSR. A restart starts interval 0. The generator counts while run is high.
module uart_rx_tick #(
    parameter int OSR    = 16,
    parameter int DIV_W  = 16,
    parameter int SIDX_W = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              restart,
    input  logic              run,
    output logic              tick,
    output logic [SIDX_W-1:0] sidx
);
    localparam logic [DIV_W-1:0]  OSR_V = DIV_W'(OSR);
    localparam logic [SIDX_W-1:0] LAST  = SIDX_W'(OSR - 1);

    logic [DIV_W-1:0]  base, rem, thresh, cnt, len_nxt, len_first;
    logic [SIDX_W-1:0] idx_nxt;

    // Base spacing and remainder, clamped for small divisors.
    always_comb begin
        if (div < OSR_V) begin
            base = DIV_W'(1);
            rem  = '0;
        end else begin
            base = div / OSR_V;
            rem  = div % OSR_V;
        end
        thresh = OSR_V - rem;
    end

    // Length of the next interval and of interval 0.
    always_comb begin
        idx_nxt   = (sidx == LAST) ? '0 : sidx + SIDX_W'(1);
        len_nxt   = base + DIV_W'(DIV_W'(idx_nxt) >= thresh);
        len_first = base + DIV_W'(thresh == '0);
    end

    assign tick = run && (cnt == '0);

    // Count down the current interval and advance the sample index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            sidx <= '0;
        end else if (restart) begin
            cnt  <= len_first - DIV_W'(1);
            sidx <= '0;
        end else if (run) begin
            if (cnt == '0) begin
                cnt  <= len_nxt - DIV_W'(1);
                sidx <= idx_nxt;
            end else begin
                cnt <= cnt - DIV_W'(1);
            end
        end
    end

    // Checker state: cycles elapsed in the current bit since restart.
    logic [DIV_W:0] chk_len;
    logic           chk_armed;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_len   <= '0;
            chk_armed <= 1'b0;
        end else if (restart) begin
            chk_len   <= (DIV_W+1)'(1);
            chk_armed <= 1'b1;
        end else if (!run) begin
            chk_armed <= 1'b0;
        end else if (tick && sidx == LAST) begin
            chk_len <= (DIV_W+1)'(1);
        end else begin
            chk_len <= chk_len + (DIV_W+1)'(1);
        end
    end

    // R2 / R3: one full bit of sample intervals spans exactly the bit length.
    a_r2_bit_length: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && tick && sidx == LAST && $stable(div)) |->
        (chk_len == ((div < OSR_V) ? (DIV_W+1)'(OSR) : {1'b0, div})));

    // R3: the strobe never stops for more than one bit while running.
    a_r3_tick_alive: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_armed && run) |-> (chk_len <= (DIV_W+1)'({1'b0, div}) + (DIV_W+1)'(OSR)));
endmodule

// File: rtl/uart_rx_frame.sv
// Frame sequencer. It detects the start edge, votes over the centre samples,
// shifts data LSB first and checks the stop bit. It assumes line is already
// synchronized and that tick/sidx come from uart_rx_tick.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int DATA_W = 8,
    parameter int SIDX_W = $clog2(OSR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              line,
    input  logic              tick,
    input  logic [SIDX_W-1:0] sidx,
    output logic              restart,
    output logic              run,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    localparam int BIT_CW = $clog2(DATA_W);
    localparam logic [SIDX_W-1:0] TAP_A = SIDX_W'(OSR/2 - 1);
    localparam logic [SIDX_W-1:0] TAP_B = SIDX_W'(OSR/2);
    localparam logic [SIDX_W-1:0] TAP_C = SIDX_W'(OSR/2 + 1);
    localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(DATA_W - 1);

    rx_state_e         state;
    logic              prev_line, smp_a, smp_b, decide, bitv;
    logic [BIT_CW-1:0] bit_cnt;
    logic [DATA_W-1:0] shreg;

    assign restart = en && (state == ST_IDLE) && prev_line && !line;
    assign run     = (state != ST_IDLE);
    assign decide  = tick && (sidx == TAP_C);
    assign bitv    = vote3(smp_a, smp_b, line);

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_line <= 1'b1;
        else        prev_line <= line;
    end

    // Capture the first two centre samples of each bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_a <= 1'b1;
            smp_b <= 1'b1;
        end else if (tick) begin
            if (sidx == TAP_A) smp_a <= line;
            if (sidx == TAP_B) smp_b <= line;
        end
    end

    // Frame state machine and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_ferr  <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: if (restart) state <= ST_START;
                    ST_START: if (decide) begin
                        state   <= bitv ? ST_IDLE : ST_DATA;
                        bit_cnt <= '0;
                    end
                    ST_DATA: if (decide) begin
                        shreg   <= {bitv, shreg[DATA_W-1:1]};
                        bit_cnt <= bit_cnt + BIT_CW'(1);
                        if (bit_cnt == LAST_BIT) state <= ST_STOP;
                    end
                    ST_STOP: if (decide) begin
                        state <= ST_IDLE;
                        if (bitv) begin
                            rx_valid <= 1'b1;
                            rx_data  <= shreg;
                        end else begin
                            rx_ferr <= 1'b1;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: a valid pulse lasts one cycle.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R7: valid and framing error are exclusive.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_ferr));
    // R8: disabled receiver produces no output next cycle.
    a_r8_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!rx_valid && !rx_ferr));
    // R6: output only follows the stop-bit state.
    a_r6_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_ferr) |-> ($past(state) == ST_STOP && state == ST_IDLE));
    // R4: a frame starts only from idle with the line low.
    a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_START) |-> ($past(line) == 1'b0));
endmodule

// File: rtl/uart_os_rx.sv
// Oversampling UART receiver top. It chains the synchronizer, the sample
// strobe generator and the frame sequencer. It assumes one stop bit, no
// parity, and div held stable while a frame is in flight.
module uart_os_rx #(
    parameter int OSR         = 16,
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  div,
    input  logic              rxd_raw,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr
);
    localparam int SIDX_W = $clog2(OSR);

    logic              line, restart, run, tick;
    logic [SIDX_W-1:0] sidx;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd_raw), .dout(line)
    );

    uart_rx_tick #(.OSR(OSR), .DIV_W(DIV_W), .SIDX_W(SIDX_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div), .restart(restart),
        .run(run), .tick(tick), .sidx(sidx)
    );

    uart_rx_frame #(.OSR(OSR), .DATA_W(DATA_W), .SIDX_W(SIDX_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(en), .line(line), .tick(tick),
        .sidx(sidx), .restart(restart), .run(run), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );
endmodule

// File: tb/uart_os_rx_tb.sv
// Self-checking bench for uart_os_rx: a vector table of divisor/byte pairs,
// then directed tests for reset, framing error, glitches, enable and streams.
module uart_os_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] div = 16'd16;
    logic        rxd_raw = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid, rx_ferr;

    int n_run = 0, n_fail = 0, cyc = 0;
    int v_cnt = 0, v_cyc = 0, f_cnt = 0, f_cyc = 0;
    logic [7:0] v_data = 8'h00;

    uart_os_rx u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div(div), .rxd_raw(rxd_raw),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ferr(rx_ferr)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor output pulses away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin v_cnt++; v_cyc = cyc; v_data = rx_data; end
        if (rx_ferr)  begin f_cnt++; f_cyc = cyc; end
    end

    localparam logic [23:0] VEC [0:7] = '{
        {16'd17, 8'hA5}, {16'd23, 8'h3C}, {16'd31, 8'hFF}, {16'd16, 8'h00},
        {16'd20, 8'h81}, {16'd47, 8'h5A}, {16'd64, 8'hC3}, {16'd5,  8'h96}
    };

    function automatic int bit_len(input int d);
        return (d < 16) ? 16 : d;
    endfunction

    // Expected posedge count from start drive to visible pulse (R2, R3, R6).
    function automatic int exp_lat(input int d);
        int b, r, s;
        b = (d < 16) ? 1 : d / 16;
        r = (d < 16) ? 0 : d % 16;
        s = 10 * b + ((r > 6) ? r - 6 : 0);
        return 3 + 9 * bit_len(d) + s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one frame; start at the current negedge. gbit flips offsets 35..37.
    task automatic send_frame(input int blen, input logic [7:0] d, input logic stopv,
                              input int gbit, output int c0);
        c0 = cyc;
        for (int b = 0; b < 10; b++) begin
            logic val;
            val = (b == 0) ? 1'b0 : (b == 9) ? stopv : d[b-1];
            for (int o = 0; o < blen; o++) begin
                rxd_raw = (b == gbit && o >= 35 && o <= 37) ? ~val : val;
                @(negedge clk);
            end
        end
        rxd_raw = 1'b1;
    endtask

    task automatic idle(input int n);
        rxd_raw = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int c0, vb, fb;
        repeat (4) @(negedge clk);
        check("R10 valid after reset", int'(rx_valid), 0);
        check("R10 ferr after reset", int'(rx_ferr), 0);
        check("R10 data after reset", int'(rx_data), 0);
        rst_n = 1'b1;
        en = 1'b1;
        idle(4);

        // Vector table: divisor, byte; data and exact latency (R1 R2 R3 R5 R6).
        foreach (VEC[i]) begin
            div = VEC[i][23:8];
            idle(40);
            vb = v_cnt;
            send_frame(bit_len(int'(VEC[i][23:8])), VEC[i][7:0], 1'b1, -1, c0);
            check("R6 one valid per frame", v_cnt - vb, 1);
            check("R5 byte value", int'(v_data), int'(VEC[i][7:0]));
            check("R2 R3 valid latency", v_cyc - c0, exp_lat(int'(VEC[i][23:8])));
        end

        // R7: low stop bit gives framing error, no valid.
        div = 16'd23;
        idle(40);
        vb = v_cnt; fb = f_cnt;
        send_frame(23, 8'h77, 1'b0, -1, c0);
        check("R7 ferr count", f_cnt - fb, 1);
        check("R7 no valid", v_cnt - vb, 0);
        check("R7 ferr latency", f_cyc - c0, exp_lat(23));
        idle(40);

        // R4: short low glitch is rejected as a false start.
        div = 16'd64;
        vb = v_cnt; fb = f_cnt;
        rxd_raw = 1'b0;
        repeat (3) @(negedge clk);
        idle(200);
        check("R4 false start no valid", v_cnt - vb, 0);
        check("R4 false start no ferr", f_cnt - fb, 0);
        send_frame(64, 8'h4E, 1'b1, -1, c0);
        check("R4 frame after false start", int'(v_data), 8'h4E);

        // R5: one disturbed centre sample in data bit 3 is voted away.
        idle(40);
        send_frame(64, 8'hB2, 1'b1, 3, c0);
        check("R5 vote over glitch", int'(v_data), 8'hB2);
        send_frame(64, 8'h0D, 1'b1, 9, c0);
        check("R5 stop vote over glitch", int'(v_data), 8'h0D);

        // R8: disabled receiver ignores a whole frame.
        div = 16'd23;
        idle(40);
        en = 1'b0;
        vb = v_cnt; fb = f_cnt;
        send_frame(23, 8'h11, 1'b1, -1, c0);
        send_frame(23, 8'h22, 1'b0, -1, c0);
        check("R8 no valid while off", v_cnt - vb, 0);
        check("R8 no ferr while off", f_cnt - fb, 0);
        en = 1'b1;
        idle(40);
        send_frame(23, 8'h6B, 1'b1, -1, c0);
        check("R8 works after enable", int'(v_data), 8'h6B);

        // R9: back-to-back streams at several divisors.
        for (int k = 0; k < 3; k++) begin
            int d, errs;
            logic [7:0] b8;
            d = (k == 0) ? 17 : (k == 1) ? 23 : 31;
            div = 16'(d);
            idle(40);
            errs = 0;
            vb = v_cnt; fb = f_cnt;
            for (int j = 0; j < 24; j++) begin
                b8 = 8'(j * 37 + k * 11 + 5);
                send_frame(d, b8, 1'b1, -1, c0);
                if (v_data != b8 || v_cyc - c0 != exp_lat(d)) errs++;
            end
            check("R9 stream frames", v_cnt - vb, 24);
            check("R9 stream no ferr", f_cnt - fb, 0);
            check("R9 stream mismatches", errs, 0);
        end

        idle(20);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule